// File: doc/BRIEF.md
# Unaligned 128-bit Load Unit

This unit serves a load of 16 consecutive bytes that may start at any byte address. The memory behind it answers only naturally aligned 16-byte reads. When the requested bytes all fall inside one aligned chunk, the unit issues a single read. When they straddle a chunk boundary, it reads the lower chunk and then the next one. It then funnels the 32 gathered bytes down by the start offset, so that the first requested byte lands in the lowest byte lane of the result.

When a request is accepted, the unit checks the control state that comes with it before any memory traffic starts. That state is an emulation flag, a task-switch flag, an OS extended-state enable, a feature-present flag, a locked-access flag, the processor-mode, canonical-address and stack-reference flags, and an alignment-check enable. If any of these calls for a fault, the unit reports exactly one fault code, chosen by a fixed priority, and reads nothing. A page-fault flag returned with either memory answer aborts the load with its own code.

The client raises `req_i` for one cycle. It then waits for a one-cycle `done_o`, which carries either the 16-byte result or a fault code. Further requests are not accepted until that happens.

Top module: `uload128_unit`

## Requirements
- R1: On success, result bits 8i+7:8i hold the memory byte at address req_addr+i, for i = 0..15 and any start offset 0..15.
- R2: If address bits 3:0 are zero, exactly one read is issued, and it is at the request address.
- R3: If address bits 3:0 are nonzero, two reads are issued in order: the first at the address with bits 3:0 cleared, the second 16 bytes above it. Every read address has bits 3:0 zero.
- R4: `mem_req_o` is a one-cycle pulse. After a pulse, no further read is issued until `mem_valid_i` has answered it.
- R5: Fault code 1 (invalid operation) is raised when the lock flag is set, or the emulation flag is set, or the OS extended-state enable is clear, or the feature-present flag is clear.
- R6: Fault code 2 (device not available) is raised when the task-switch flag is set.
- R7: In 64-bit mode, a non-canonical address raises code 3 (general protection), or code 4 (stack fault) when the request references the stack. Outside 64-bit mode the non-canonical flag has no effect.
- R8: With alignment checking enabled, an address whose bits 2:0 are nonzero raises code 5. An address that is a multiple of 8 loads normally.
- R9: Priority runs code 1, then 2, then 3 or 4, then 5. Only one code is reported. A fault found at request time gives `done_o` in the cycle after acceptance, and no read is issued.
- R10: A page-fault flag that arrives with `mem_valid_i` on either read ends the load with code 6 in the next cycle. No further read is issued after it.
- R11: `done_o` is a one-cycle pulse in the cycle after the last read's `mem_valid_i`. On success it has `fault_o`=0 and code 0. On a fault it has `fault_o`=1.
- R12: `req_i` raised while a load is in progress is ignored.
- R13: Synchronous active-low reset returns the unit to idle with `done_o`, `fault_o` and `mem_req_o` low, including when a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | One-cycle load request |
| req_addr_i | input | AW | Byte address of the first byte |
| req_lock_i | input | 1 | Locked-access flag on the request |
| req_stack_i | input | 1 | Request references the stack segment |
| emul_i | input | 1 | Emulation flag |
| os_ok_i | input | 1 | OS extended-state enable |
| feat_ok_i | input | 1 | Feature-present flag |
| ts_i | input | 1 | Task-switch flag |
| long_mode_i | input | 1 | Processor is in 64-bit mode |
| noncanon_i | input | 1 | Request address is non-canonical |
| ac_en_i | input | 1 | Alignment checking enabled |
| mem_req_o | output | 1 | Aligned read request pulse |
| mem_addr_o | output | AW | Aligned read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8*BYTES | Aligned read data, byte 0 in bits 7:0 |
| mem_pf_i | input | 1 | Page fault on this read |
| done_o | output | 1 | Load finished (one cycle) |
| data_o | output | 8*BYTES | Loaded value |
| fault_o | output | 1 | Load ended in a fault |
| fault_code_o | output | 3 | Fault code (0 none, 1..6 as above) |

## Verification
A wrong state in this unit shows up at the ports as a read pulse at the wrong time or address, a missing or extra second read, or a `done_o` that is early, late or doubled. The reference model checks read traffic and `done_o` on every clock, so any such error surfaces in the cycle it happens. A funnel or latch error shows only in `data_o` when `done_o` rises. For that reason the start offsets cover zero, the middle and the top lane. Priority mistakes show as a wrong code when several fault conditions are raised together.

// File: rtl/uld_pkg.sv
// Shared types for the unaligned load unit: fault codes and controller states.
package uld_pkg;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_NM   = 3'd2,
        FLT_GP   = 3'd3,
        FLT_SS   = 3'd4,
        FLT_AC   = 3'd5,
        FLT_PF   = 3'd6
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISS_LO,
        ST_WT_LO,
        ST_ISS_HI,
        ST_WT_HI
    } state_e;

endpackage

// File: rtl/uld_fault_gate.sv
// Request-time fault classifier.
// Takes the control flags that accompany a request and returns the single
// highest-priority fault code. Assumes the flags are valid while req_i is high.
module uld_fault_gate
    import uld_pkg::*;
#(
    parameter int AW  = 48,
    parameter int ACW = 3
) (
    input  logic [AW-1:0] addr_i,
    input  logic          lock_i,
    input  logic          emul_i,
    input  logic          os_ok_i,
    input  logic          feat_ok_i,
    input  logic          ts_i,
    input  logic          long_mode_i,
    input  logic          noncanon_i,
    input  logic          stack_ref_i,
    input  logic          ac_en_i,
    output fault_e        code_o
);

    logic bad_op;
    logic misalign;

    // Classify the flags into fault classes.
    always_comb begin
        bad_op   = lock_i | emul_i | ~os_ok_i | ~feat_ok_i;
        misalign = ac_en_i & (addr_i[ACW-1:0] != '0);
    end

    // Pick the highest-priority fault.
    always_comb begin
        if (bad_op)                         code_o = FLT_UD;
        else if (ts_i)                      code_o = FLT_NM;
        else if (long_mode_i && noncanon_i) code_o = stack_ref_i ? FLT_SS : FLT_GP;
        else if (misalign)                  code_o = FLT_AC;
        else                                code_o = FLT_NONE;
    end

    // A locked access always outranks every other fault (R5, R9).
    always_comb begin
        if (lock_i) begin
            a_r9_lock_wins: assert (code_o == FLT_UD);
        end
    end

endmodule

// File: rtl/uld_byte_funnel.sv
// Byte funnel.
// Selects BYTES consecutive bytes out of two adjacent aligned chunks, starting
// at byte offset off_i of the low chunk. Purely combinational.
module uld_byte_funnel #(
    parameter int BYTES = 16,
    parameter int OFFW  = $clog2(BYTES)
) (
    input  logic [8*BYTES-1:0] lo_i,
    input  logic [8*BYTES-1:0] hi_i,
    input  logic [OFFW-1:0]    off_i,
    output logic [8*BYTES-1:0] out_o
);

    localparam int IW = OFFW + 4;

    logic [16*BYTES-1:0] cat;

    assign cat = {hi_i, lo_i};

    // One byte multiplexer per output lane.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [IW-1:0] pos;
        // Bit position of the source byte for this lane.
        always_comb pos = IW'({off_i, 3'b000}) + IW'(8 * b);
        assign out_o[8*b +: 8] = cat[pos +: 8];
    end

    // A zero offset must pass the low chunk through unchanged (R1).
    always_comb begin
        if (off_i == '0) begin
            a_r1_zero_offset: assert (out_o == lo_i);
        end
    end

endmodule

// File: rtl/uload128_unit.sv
// Unaligned load unit, top level.
// Accepts one load at a time. It checks faults at acceptance, issues one or
// two aligned chunk reads and funnels the result. Assumes the memory answers
// every read pulse with exactly one mem_valid_i, no earlier than the cycle
// after the pulse.
module uload128_unit
    import uld_pkg::*;
#(
    parameter int AW    = 48,
    parameter int BYTES = 16,
    parameter int ACW   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [AW-1:0]      req_addr_i,
    input  logic               req_lock_i,
    input  logic               req_stack_i,
    input  logic               emul_i,
    input  logic               os_ok_i,
    input  logic               feat_ok_i,
    input  logic               ts_i,
    input  logic               long_mode_i,
    input  logic               noncanon_i,
    input  logic               ac_en_i,
    output logic               mem_req_o,
    output logic [AW-1:0]      mem_addr_o,
    input  logic               mem_valid_i,
    input  logic [8*BYTES-1:0] mem_data_i,
    input  logic               mem_pf_i,
    output logic               done_o,
    output logic [8*BYTES-1:0] data_o,
    output logic               fault_o,
    output logic [2:0]         fault_code_o
);

    localparam int OFFW = $clog2(BYTES);
    localparam int DW   = 8 * BYTES;

    state_e          state_q;
    logic [AW-1:0]   base_q;
    logic [OFFW-1:0] off_q;
    logic [DW-1:0]   lo_q;
    logic            done_q;
    logic            fault_q;
    fault_e          code_q;
    logic [DW-1:0]   data_q;
    fault_e          gate_code;
    logic [DW-1:0]   merged;

    uld_fault_gate #(
        .AW  (AW),
        .ACW (ACW)
    ) u_gate (
        .addr_i      (req_addr_i),
        .lock_i      (req_lock_i),
        .emul_i      (emul_i),
        .os_ok_i     (os_ok_i),
        .feat_ok_i   (feat_ok_i),
        .ts_i        (ts_i),
        .long_mode_i (long_mode_i),
        .noncanon_i  (noncanon_i),
        .stack_ref_i (req_stack_i),
        .ac_en_i     (ac_en_i),
        .code_o      (gate_code)
    );

    uld_byte_funnel #(
        .BYTES (BYTES),
        .OFFW  (OFFW)
    ) u_funnel (
        .lo_i  (lo_q),
        .hi_i  (mem_data_i),
        .off_i (off_q),
        .out_o (merged)
    );

    // Controller: accept, issue reads, collect answers, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            off_q   <= '0;
            lo_q    <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            code_q  <= FLT_NONE;
            data_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        if (gate_code != FLT_NONE) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            code_q  <= gate_code;
                            data_q  <= '0;
                        end else begin
                            base_q  <= {req_addr_i[AW-1:OFFW], {OFFW{1'b0}}};
                            off_q   <= req_addr_i[OFFW-1:0];
                            state_q <= ST_ISS_LO;
                        end
                    end
                end
                ST_ISS_LO: state_q <= ST_WT_LO;
                ST_WT_LO: begin
                    if (mem_valid_i) begin
                        if (mem_pf_i) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            code_q  <= FLT_PF;
                            data_q  <= '0;
                            state_q <= ST_IDLE;
                        end else if (off_q == '0) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            code_q  <= FLT_NONE;
                            data_q  <= mem_data_i;
                            state_q <= ST_IDLE;
                        end else begin
                            lo_q    <= mem_data_i;
                            state_q <= ST_ISS_HI;
                        end
                    end
                end
                ST_ISS_HI: state_q <= ST_WT_HI;
                ST_WT_HI: begin
                    if (mem_valid_i) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                        if (mem_pf_i) begin
                            fault_q <= 1'b1;
                            code_q  <= FLT_PF;
                            data_q  <= '0;
                        end else begin
                            fault_q <= 1'b0;
                            code_q  <= FLT_NONE;
                            data_q  <= merged;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port from the controller state.
    always_comb begin
        mem_req_o  = (state_q == ST_ISS_LO) || (state_q == ST_ISS_HI);
        mem_addr_o = (state_q == ST_ISS_HI) ? base_q + AW'(BYTES) : base_q;
    end

    assign done_o       = done_q;
    assign fault_o      = fault_q;
    assign fault_code_o = code_q;
    assign data_o       = data_q;

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r4_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    a_r3_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[OFFW-1:0] == '0));

    a_r9_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

endmodule

// File: tb/uload128_unit_bench.sv
// Bench for the unaligned load unit. It has a behavioural memory, computes
// the expected fault codes and data from the requirements, and compares the
// read port and done on every clock of each load.
module uload128_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_i = 1'b0;
    logic [47:0]  req_addr_i = '0;
    logic         req_lock_i = 1'b0;
    logic         req_stack_i = 1'b0;
    logic         emul_i = 1'b0;
    logic         os_ok_i = 1'b1;
    logic         feat_ok_i = 1'b1;
    logic         ts_i = 1'b0;
    logic         long_mode_i = 1'b1;
    logic         noncanon_i = 1'b0;
    logic         ac_en_i = 1'b0;
    logic         mem_req_o;
    logic [47:0]  mem_addr_o;
    logic         mem_valid_i = 1'b0;
    logic [127:0] mem_data_i = '0;
    logic         mem_pf_i = 1'b0;
    logic         done_o;
    logic [127:0] data_o;
    logic         fault_o;
    logic [2:0]   fault_code_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    uload128_unit u_uload128_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .req_addr_i   (req_addr_i),
        .req_lock_i   (req_lock_i),
        .req_stack_i  (req_stack_i),
        .emul_i       (emul_i),
        .os_ok_i      (os_ok_i),
        .feat_ok_i    (feat_ok_i),
        .ts_i         (ts_i),
        .long_mode_i  (long_mode_i),
        .noncanon_i   (noncanon_i),
        .ac_en_i      (ac_en_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_valid_i  (mem_valid_i),
        .mem_data_i   (mem_data_i),
        .mem_pf_i     (mem_pf_i),
        .done_o       (done_o),
        .data_o       (data_o),
        .fault_o      (fault_o),
        .fault_code_o (fault_code_o)
    );

    function automatic logic [7:0] mbyte(input logic [47:0] a);
        return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A ^ a[23:16];
    endfunction

    function automatic logic [127:0] span(input logic [47:0] a);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = mbyte(a + 48'(i));
        return r;
    endfunction

    function automatic logic [2:0] exp_fault(input logic [47:0] a);
        if (req_lock_i || emul_i || !os_ok_i || !feat_ok_i) return 3'd1;
        if (ts_i) return 3'd2;
        if (long_mode_i && noncanon_i) return req_stack_i ? 3'd4 : 3'd3;
        if (ac_en_i && (a[2:0] != 3'd0)) return 3'd5;
        return 3'd0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clean_flags();
        req_lock_i = 0; req_stack_i = 0; emul_i = 0; os_ok_i = 1; feat_ok_i = 1;
        ts_i = 0; long_mode_i = 1; noncanon_i = 0; ac_en_i = 0;
    endtask

    // One load: pf_chunk 0 none, 1 first read, 2 second read; lat >= 1.
    task automatic run(input string tag, input logic [47:0] a,
                       input int pf_chunk, input int lat, input bit poke);
        logic [2:0]  ef;
        logic [47:0] base;
        int          chunks;
        ef     = exp_fault(a);
        base   = {a[47:4], 4'h0};
        chunks = (a[3:0] == 4'h0) ? 1 : 2;
        @(negedge clk);
        req_i = 1; req_addr_i = a;
        @(negedge clk);
        req_i = 0;
        if (ef != 3'd0) begin
            chk(tag, "done", 128'(done_o), 128'd1);
            chk(tag, "fault", 128'(fault_o), 128'd1);
            chk(tag, "code", 128'(fault_code_o), 128'(ef));
            chk(tag, "no read", 128'(mem_req_o), 128'd0);
            @(negedge clk);
            chk(tag, "done pulse", 128'(done_o), 128'd0);
            chk(tag, "no read", 128'(mem_req_o), 128'd0);
            return;
        end
        chk(tag, "done early", 128'(done_o), 128'd0);
        for (int c = 0; c < chunks; c++) begin
            chk(tag, "read req", 128'(mem_req_o), 128'd1);
            chk(tag, "read addr", 128'(mem_addr_o), 128'(base + 48'(16 * c)));
            @(negedge clk);
            chk(tag, "read pulse", 128'(mem_req_o), 128'd0);
            chk(tag, "done early", 128'(done_o), 128'd0);
            if (poke && c == 0) begin
                req_i = 1; req_lock_i = 1;
                @(negedge clk);
                req_i = 0; req_lock_i = 0;
                chk("R12", "busy req ignored done", 128'(done_o), 128'd0);
                chk("R12", "busy req ignored read", 128'(mem_req_o), 128'd0);
            end
            for (int w = 1; w < lat; w++) begin
                @(negedge clk);
                chk(tag, "wait read", 128'(mem_req_o), 128'd0);
                chk(tag, "wait done", 128'(done_o), 128'd0);
            end
            mem_valid_i = 1;
            mem_data_i  = span(base + 48'(16 * c));
            mem_pf_i    = (pf_chunk == c + 1);
            @(negedge clk);
            mem_valid_i = 0; mem_pf_i = 0; mem_data_i = '0;
            if (pf_chunk == c + 1) begin
                chk("R10", "pf done", 128'(done_o), 128'd1);
                chk("R10", "pf fault", 128'(fault_o), 128'd1);
                chk("R10", "pf code", 128'(fault_code_o), 128'd6);
                chk("R10", "no read after pf", 128'(mem_req_o), 128'd0);
                break;
            end else if (c == chunks - 1) begin
                chk(tag, "done", 128'(done_o), 128'd1);
                chk("R11", "fault clear", 128'(fault_o), 128'd0);
                chk("R11", "code clear", 128'(fault_code_o), 128'd0);
                chk("R1", "data", data_o, span(a));
            end else begin
                chk(tag, "done mid", 128'(done_o), 128'd0);
            end
        end
        @(negedge clk);
        chk("R11", "done pulse", 128'(done_o), 128'd0);
        chk(tag, "idle read", 128'(mem_req_o), 128'd0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", "reset done", 128'(done_o), 128'd0);
        chk("R13", "reset fault", 128'(fault_o), 128'd0);
        chk("R13", "reset read", 128'(mem_req_o), 128'd0);
        rst_n = 1;
        @(negedge clk);

        run("R2", 48'h0000_1234_5670, 0, 1, 0);
        run("R3", 48'h0000_0ABC_0015, 0, 2, 0);
        run("R3", 48'h0000_0000_FFFF, 0, 1, 0);
        run("R3", 48'h0000_7777_0001, 0, 3, 0);
        for (int k = 0; k < 16; k++) run("R1", 48'h0000_0004_2300 + 48'(k), 0, 1 + (k % 3), 0);

        ac_en_i = 1;
        run("R8", 48'h0000_0000_2008, 0, 1, 0);
        run("R8", 48'h0000_0000_2003, 0, 1, 0);
        run("R8", 48'h0000_0000_2010, 0, 1, 0);
        clean_flags();

        req_lock_i = 1; run("R5", 48'h0000_0000_3000, 0, 1, 0); clean_flags();
        emul_i = 1;     run("R5", 48'h0000_0000_3001, 0, 1, 0); clean_flags();
        os_ok_i = 0;    run("R5", 48'h0000_0000_3002, 0, 1, 0); clean_flags();
        feat_ok_i = 0;  run("R5", 48'h0000_0000_3003, 0, 1, 0); clean_flags();
        ts_i = 1;       run("R6", 48'h0000_0000_3004, 0, 1, 0); clean_flags();

        noncanon_i = 1;
        run("R7", 48'h8000_0000_0005, 0, 1, 0);
        req_stack_i = 1;
        run("R7", 48'h8000_0000_0006, 0, 1, 0);
        long_mode_i = 0;
        run("R7", 48'h0000_0000_4006, 0, 1, 0);
        clean_flags();

        ts_i = 1; req_lock_i = 1;
        run("R9", 48'h0000_0000_5000, 0, 1, 0); clean_flags();
        ts_i = 1; noncanon_i = 1;
        run("R9", 48'h0000_0000_5001, 0, 1, 0); clean_flags();
        noncanon_i = 1; ac_en_i = 1;
        run("R9", 48'h0000_0000_5003, 0, 1, 0); clean_flags();

        run("R10", 48'h0000_0000_6000, 1, 1, 0);
        run("R10", 48'h0000_0000_6009, 1, 2, 0);
        run("R10", 48'h0000_0000_600C, 2, 1, 0);

        run("R4", 48'h0000_0000_7007, 0, 4, 1);
        run("R12", 48'h0000_0000_7100, 0, 2, 1);

        @(negedge clk);
        req_i = 1; req_addr_i = 48'h0000_0000_8004;
        @(negedge clk);
        req_i = 0;
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R13", "reset mid read", 128'(mem_req_o), 128'd0);
        chk("R13", "reset mid done", 128'(done_o), 128'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R13", "idle after reset", 128'(mem_req_o), 128'd0);
        run("R13", 48'h0000_0000_8105, 0, 1, 0);

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule